// File: doc/BRIEF.md
# Instrument Status Reporting Hierarchy

This block gathers the status of a measurement instrument into a two-level summary tree. A standard event register captures single-cycle event pulses, such as a malformed command. A questionable-data register watches level conditions through programmable rising-edge and falling-edge filters. Each event register is masked by its own enable register and reduced to one summary bit of an 8-bit status byte. The status byte is masked again by a service-request enable register. The result is a request-service bit and an active-high service-request line.

A host reaches every register through a simple access port with a one-cycle read latency. Through this port it writes the enable and filter registers, reads the condition register, and reads the event registers, which clears them. A serial-poll read returns the live status byte. A separate clear-status strobe wipes all latched events at once. A level input marks automatic interpolator calibration as switched off. While it is high, the time, frequency and phase conditions of the questionable-data register are held active.

Top module: `stat_report_top`

## Requirements
- R1: After reset, both event registers and all three enable registers are zero, the rising filter is all ones, the falling filter is zero, the status byte is 0 and `srq` is low.
- R2: A 1 on bit k of `std_evt_in` sets bit k of the standard event register, where bit 5 means command error. Set bits stay set until they are read or cleared.
- R3: Status byte bit 5 (weight 32) is 1 exactly when some standard event bit is set whose enable bit is also set.
- R4: Status byte bit 3 (weight 8) is 1 exactly when some questionable event bit is set whose enable bit is also set.
- R5: Status byte bit 6 (weight 64) and `srq` are 1 exactly when some other status byte bit is set whose service-request enable bit is also set. The service-request enable bit 6 is never stored and always reads 0. With both standard masks at 32, a command error gives a serial poll of 96.
- R6: While `autocal_off` is high, questionable condition bits 2, 5 and 6 read 1, whatever `q_cond_in` holds.
- R7: A questionable event bit latches on a 0-to-1 change of its condition only when its rising-filter bit is set. With event enable 0x64, service-request enable 8 and the default filters, switching calibration off gives a serial poll of 72.
- R8: A questionable event bit latches on a 1-to-0 change of its condition when its falling-filter bit is set. When both filter bits are set, either change latches it.
- R9: Reading an event register returns its contents and clears it. An event arriving in the same cycle as the read stays latched. Reading the condition register clears nothing.
- R10: A `clr_status` cycle zeroes both event registers and takes priority over events arriving in that cycle. It leaves the enable and filter registers unchanged.
- R11: The address map is 0 serial poll, 1 service-request enable, 2 standard event, 3 standard enable, 4 questionable condition, 5 questionable event, 6 questionable enable, 7 rising filter, 8 falling filter. `acc_rdata` holds the read data in the cycle after the access, and holds 0 after a cycle with no read.
- R12: The status byte has no storage of its own. `srq` falls in the cycle after the last enabled event bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| std_evt_in | input | 8 | Single-cycle standard event pulses (bit 5 command error) |
| q_cond_in | input | 16 | Questionable-data condition levels |
| autocal_off | input | 1 | High while automatic calibration is disabled |
| clr_status | input | 1 | Clear all event registers |
| acc_en | input | 1 | Register access strobe |
| acc_wr | input | 1 | 1 write, 0 read |
| acc_addr | input | 4 | Register address |
| acc_wdata | input | 16 | Write data |
| acc_rdata | output | 16 | Read data, one cycle after the access |
| status_byte | output | 8 | Live status byte |
| srq | output | 1 | Service request, active high |

## Verification
Events and condition edges that arrive at a clock edge land in the event registers at that same edge. The status byte and `srq` are combinational from those registers, so they are due one cycle after the stimulus. Read data is registered and is due one cycle after the access. The bench drives inputs and samples outputs on the falling edge. A behavioural model steps on each rising edge, and its summary byte, `srq` and read data are compared with the design at every falling edge. Directed reads also check the fixed poll values 96 and 72 and the read-clear and clear-status corner cases.

// File: rtl/stat_pkg.sv
// Shared constants and types for the status reporting hierarchy.
// Assumes an 8-bit status byte with fixed summary bit positions.
package stat_pkg;

    localparam int STD_W   = 8;
    localparam int Q_W     = 16;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 16;
    localparam int STB_W   = 8;

    // Status byte bit positions that a host decodes.
    localparam int QSB_BIT = 3;
    localparam int ESB_BIT = 5;
    localparam int RQS_BIT = 6;

    // Questionable condition bits forced while calibration is disabled.
    localparam int CAL_TIME_BIT  = 2;
    localparam int CAL_FREQ_BIT  = 5;
    localparam int CAL_PHASE_BIT = 6;
    localparam logic [Q_W-1:0] CAL_MASK =
        (Q_W'(1) << CAL_TIME_BIT) | (Q_W'(1) << CAL_FREQ_BIT) | (Q_W'(1) << CAL_PHASE_BIT);

    localparam logic [STB_W-1:0] SVC_WR_MASK = ~(STB_W'(1) << RQS_BIT);

    typedef enum logic [ADDR_W-1:0] {
        A_SPOLL   = 4'd0,
        A_SVC_EN  = 4'd1,
        A_STD_EVT = 4'd2,
        A_STD_EN  = 4'd3,
        A_Q_COND  = 4'd4,
        A_Q_EVT   = 4'd5,
        A_Q_EN    = 4'd6,
        A_Q_RISE  = 4'd7,
        A_Q_FALL  = 4'd8
    } reg_addr_e;

endpackage

// File: rtl/stat_event_reg.sv
// Latched event register with optional transition filtering.
// EDGE_MODE=1: latches on filtered edges of a level input (rise_en/fall_en).
// EDGE_MODE=0: latches input pulses on bits where rise_en|fall_en is set.
// Clear-all dominates; a read-clear keeps events arriving in the same cycle.
module stat_event_reg #(
    parameter int W         = 16,
    parameter bit EDGE_MODE = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sig_in,
    input  logic [W-1:0] rise_en,
    input  logic [W-1:0] fall_en,
    input  logic         rd_clr,
    input  logic         clr_all,
    output logic [W-1:0] evt_q
);

    logic [W-1:0] set_bits;

    generate
        if (EDGE_MODE) begin : g_edge
            logic [W-1:0] prev_q;

            // Remember the previous condition level for edge detection.
            always_ff @(posedge clk) begin
                if (!rst_n) prev_q <= '0;
                else        prev_q <= sig_in;
            end

            // Select the edges the filters allow.
            always_comb begin
                set_bits = (sig_in & ~prev_q & rise_en) | (~sig_in & prev_q & fall_en);
            end
        end else begin : g_pulse
            // Pulses pass on any bit with a capture enable.
            always_comb begin
                set_bits = sig_in & (rise_en | fall_en);
            end
        end
    endgenerate

    // Sticky event storage with read-clear and clear-all.
    always_ff @(posedge clk) begin
        if (!rst_n)       evt_q <= '0;
        else if (clr_all) evt_q <= '0;
        else if (rd_clr)  evt_q <= set_bits;
        else              evt_q <= evt_q | set_bits;
    end

endmodule

// File: rtl/stat_summary.sv
// Builds the status byte from the two event registers and their masks,
// and computes the request-service bit against the service-request mask.
// Purely combinational; the status byte has no storage.
module stat_summary
    import stat_pkg::*;
(
    input  logic [STD_W-1:0] std_evt,
    input  logic [STD_W-1:0] std_en,
    input  logic [Q_W-1:0]   q_evt,
    input  logic [Q_W-1:0]   q_en,
    input  logic [STB_W-1:0] svc_en,
    output logic [STB_W-1:0] status_byte,
    output logic             srq
);

    logic [STB_W-1:0] base_byte;
    logic             rqs;

    // Place the two summary bits into an otherwise empty byte.
    always_comb begin
        base_byte          = '0;
        base_byte[ESB_BIT] = |(std_evt & std_en);
        base_byte[QSB_BIT] = |(q_evt & q_en);
    end

    // Request-service bit from the masked byte, excluding itself.
    always_comb begin
        rqs = |(base_byte & svc_en & SVC_WR_MASK);
    end

    // Merge request-service bit and drive the request line.
    always_comb begin
        status_byte          = base_byte;
        status_byte[RQS_BIT] = rqs;
        srq                  = rqs;
    end

endmodule

// File: rtl/stat_regfile.sv
// Host-facing register file: enable and filter storage, read mux with
// one-cycle latency, and read-clear strobes for the event registers.
// Assumes one access per cycle; reads and writes to unmapped addresses are inert.
module stat_regfile
    import stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic [STB_W-1:0]  status_byte,
    input  logic [STD_W-1:0]  std_evt,
    input  logic [Q_W-1:0]    q_cond,
    input  logic [Q_W-1:0]    q_evt,
    output logic [STB_W-1:0]  svc_en,
    output logic [STD_W-1:0]  std_en,
    output logic [Q_W-1:0]    q_en,
    output logic [Q_W-1:0]    q_rise,
    output logic [Q_W-1:0]    q_fall,
    output logic              std_rd_clr,
    output logic              q_rd_clr,
    output logic [DATA_W-1:0] acc_rdata
);

    reg_addr_e         addr;
    logic              do_wr;
    logic              do_rd;
    logic [DATA_W-1:0] rd_mux;

    // Decode the access type.
    always_comb begin
        addr  = reg_addr_e'(acc_addr);
        do_wr = acc_en & acc_wr;
        do_rd = acc_en & ~acc_wr;
    end

    // Read-clear strobes for the two event registers.
    always_comb begin
        std_rd_clr = do_rd && (addr == A_STD_EVT);
        q_rd_clr   = do_rd && (addr == A_Q_EVT);
    end

    // Enable and filter register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            svc_en <= '0;
            std_en <= '0;
            q_en   <= '0;
            q_rise <= '1;
            q_fall <= '0;
        end else if (do_wr) begin
            case (addr)
                A_SVC_EN: svc_en <= acc_wdata[STB_W-1:0] & SVC_WR_MASK;
                A_STD_EN: std_en <= acc_wdata[STD_W-1:0];
                A_Q_EN:   q_en   <= acc_wdata[Q_W-1:0];
                A_Q_RISE: q_rise <= acc_wdata[Q_W-1:0];
                A_Q_FALL: q_fall <= acc_wdata[Q_W-1:0];
                default:  ;
            endcase
        end
    end

    // Select the value a read returns.
    always_comb begin
        rd_mux = '0;
        case (addr)
            A_SPOLL:   rd_mux = DATA_W'(status_byte);
            A_SVC_EN:  rd_mux = DATA_W'(svc_en);
            A_STD_EVT: rd_mux = DATA_W'(std_evt);
            A_STD_EN:  rd_mux = DATA_W'(std_en);
            A_Q_COND:  rd_mux = DATA_W'(q_cond);
            A_Q_EVT:   rd_mux = DATA_W'(q_evt);
            A_Q_EN:    rd_mux = DATA_W'(q_en);
            A_Q_RISE:  rd_mux = DATA_W'(q_rise);
            A_Q_FALL:  rd_mux = DATA_W'(q_fall);
            default:   rd_mux = '0;
        endcase
    end

    // Register read data; zero when no read took place.
    always_ff @(posedge clk) begin
        if (!rst_n)     acc_rdata <= '0;
        else if (do_rd) acc_rdata <= rd_mux;
        else            acc_rdata <= '0;
    end

endmodule

// File: rtl/stat_report_top.sv
// Status reporting hierarchy top: standard event register (pulse capture),
// questionable-data register (edge filtered), status byte and service request.
// Assumes event inputs are synchronous to clk.
module stat_report_top
    import stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        std_evt_in,
    input  logic [15:0]       q_cond_in,
    input  logic              autocal_off,
    input  logic              clr_status,
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic [3:0]        acc_addr,
    input  logic [15:0]       acc_wdata,
    output logic [15:0]       acc_rdata,
    output logic [7:0]        status_byte,
    output logic              srq
);

    logic [Q_W-1:0]   q_cond_eff;
    logic [STD_W-1:0] esr_q;
    logic [Q_W-1:0]   qevt_q;
    logic [STB_W-1:0] sre_q;
    logic [STD_W-1:0] ese_q;
    logic [Q_W-1:0]   qen_q;
    logic [Q_W-1:0]   qrise_q;
    logic [Q_W-1:0]   qfall_q;
    logic             std_rd_clr;
    logic             q_rd_clr;

    // Force calibration-dependent conditions while calibration is off.
    always_comb begin
        q_cond_eff = q_cond_in | (autocal_off ? CAL_MASK : '0);
    end

    stat_event_reg #(.W(STD_W), .EDGE_MODE(1'b0)) u_std_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .sig_in  (std_evt_in),
        .rise_en ({STD_W{1'b1}}),
        .fall_en ({STD_W{1'b0}}),
        .rd_clr  (std_rd_clr),
        .clr_all (clr_status),
        .evt_q   (esr_q)
    );

    stat_event_reg #(.W(Q_W), .EDGE_MODE(1'b1)) u_q_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .sig_in  (q_cond_eff),
        .rise_en (qrise_q),
        .fall_en (qfall_q),
        .rd_clr  (q_rd_clr),
        .clr_all (clr_status),
        .evt_q   (qevt_q)
    );

    stat_summary u_sum (
        .std_evt     (esr_q),
        .std_en      (ese_q),
        .q_evt       (qevt_q),
        .q_en        (qen_q),
        .svc_en      (sre_q),
        .status_byte (status_byte),
        .srq         (srq)
    );

    stat_regfile u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_en      (acc_en),
        .acc_wr      (acc_wr),
        .acc_addr    (acc_addr),
        .acc_wdata   (acc_wdata),
        .status_byte (status_byte),
        .std_evt     (esr_q),
        .q_cond      (q_cond_eff),
        .q_evt       (qevt_q),
        .svc_en      (sre_q),
        .std_en      (ese_q),
        .q_en        (qen_q),
        .q_rise      (qrise_q),
        .q_fall      (qfall_q),
        .std_rd_clr  (std_rd_clr),
        .q_rd_clr    (q_rd_clr),
        .acc_rdata   (acc_rdata)
    );

endmodule

// File: rtl/stat_report_chk.sv
// Assertion checker for stat_report_top, attached by bind.
// Observes ports plus the event and enable registers.
module stat_report_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  std_evt_in,
    input logic        clr_status,
    input logic        acc_en,
    input logic        acc_wr,
    input logic [3:0]  acc_addr,
    input logic [7:0]  esr,
    input logic [15:0] qevt,
    input logic [7:0]  ese,
    input logic [7:0]  sre,
    input logic [7:0]  status_byte,
    input logic        srq
);

    logic rd_esr;
    assign rd_esr = acc_en && !acc_wr && (acc_addr == 4'd2);

    // R10: clear-status empties both event registers
    a_r10_clear_events: assert property (@(posedge clk) disable iff (!rst_n)
        clr_status |=> (esr == 8'h00) && (qevt == 16'h0000) && !srq);

    // R10: clear-status keeps the masks
    a_r10_masks_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_status && !(acc_en && acc_wr)) |=> ($stable(ese) && $stable(sre)));

    // R2: command error latches bit 5
    a_r2_cmd_err_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (std_evt_in[5] && !clr_status) |=> esr[5]);

    // R2: set bits persist without read or clear
    a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_status && !rd_esr) |=> ((esr & $past(esr)) == $past(esr)));

    // R9: a read with no new event leaves the register empty
    a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_esr && (std_evt_in == 8'h00) && !clr_status) |=> (esr == 8'h00));

    // R5: request needs an enabled summary bit
    a_r5_srq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        srq |-> ((status_byte & sre & 8'hBF) != 8'h00));

    // R5: request-service bit never stored in its own mask
    a_r5_no_self_mask: assert property (@(posedge clk) disable iff (!rst_n)
        !sre[6]);

endmodule

bind stat_report_top stat_report_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .std_evt_in  (std_evt_in),
    .clr_status  (clr_status),
    .acc_en      (acc_en),
    .acc_wr      (acc_wr),
    .acc_addr    (acc_addr),
    .esr         (esr_q),
    .qevt        (qevt_q),
    .ese         (ese_q),
    .sre         (sre_q),
    .status_byte (status_byte),
    .srq         (srq)
);

// File: tb/stat_report_top_test.sv
// Bench: behavioural model stepped on rising edges, compared on falling edges,
// plus directed checks of the fixed poll values and corner cases.
module stat_report_top_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  std_evt_in = '0;
    logic [15:0] q_cond_in = '0;
    logic        autocal_off = 1'b0;
    logic        clr_status = 1'b0;
    logic        acc_en = 1'b0;
    logic        acc_wr = 1'b0;
    logic [3:0]  acc_addr = '0;
    logic [15:0] acc_wdata = '0;
    logic [15:0] acc_rdata;
    logic [7:0]  status_byte;
    logic        srq;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Model state
    int m_esr, m_ese, m_sre, m_qevt, m_qen, m_rise, m_fall, m_prev, m_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    stat_report_top uut (
        .clk(clk), .rst_n(rst_n), .std_evt_in(std_evt_in), .q_cond_in(q_cond_in),
        .autocal_off(autocal_off), .clr_status(clr_status), .acc_en(acc_en),
        .acc_wr(acc_wr), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .status_byte(status_byte), .srq(srq)
    );

    function automatic int m_stb();
        int b;
        b = 0;
        if ((m_esr & m_ese) != 0)  b = b | 32;   // R3
        if ((m_qevt & m_qen) != 0) b = b | 8;    // R4
        if ((b & m_sre & 'hBF) != 0) b = b | 64; // R5
        return b;
    endfunction

    // Step the model on each rising edge.
    always @(posedge clk) begin
        int cond, edges, rd, a;
        if (!rst_n) begin
            m_esr = 0; m_ese = 0; m_sre = 0; m_qevt = 0; m_qen = 0;
            m_rise = 'hFFFF; m_fall = 0; m_prev = 0; m_rdata = 0;
        end else begin
            cond  = int'(q_cond_in) | (autocal_off ? 'h64 : 0);
            edges = ((cond & ~m_prev & m_rise) | (~cond & m_prev & m_fall)) & 'hFFFF;
            a  = int'(acc_addr);
            rd = 0;
            if (acc_en && !acc_wr) begin
                case (a)
                    0: rd = m_stb();
                    1: rd = m_sre;
                    2: rd = m_esr;
                    3: rd = m_ese;
                    4: rd = cond;
                    5: rd = m_qevt;
                    6: rd = m_qen;
                    7: rd = m_rise;
                    8: rd = m_fall;
                    default: rd = 0;
                endcase
                if (a == 2) m_esr = 0;
                if (a == 5) m_qevt = 0;
            end
            m_esr  = m_esr | int'(std_evt_in);
            m_qevt = m_qevt | edges;
            if (acc_en && acc_wr) begin
                case (a)
                    1: m_sre  = int'(acc_wdata) & 'hBF;
                    3: m_ese  = int'(acc_wdata) & 'hFF;
                    6: m_qen  = int'(acc_wdata);
                    7: m_rise = int'(acc_wdata);
                    8: m_fall = int'(acc_wdata);
                    default: ;
                endcase
            end
            if (clr_status) begin m_esr = 0; m_qevt = 0; end
            m_prev  = cond;
            m_rdata = rd;
        end
    end

    task automatic check(input string req, input int got, input int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // Compare against the model on every falling edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R3/R4/R5 status byte", int'(status_byte), m_stb());
            check("R5/R12 srq", int'(srq), (m_stb() >> 6) & 1);
            check("R11 read data", int'(acc_rdata), m_rdata);
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        acc_en = 1'b1; acc_wr = 1'b1; acc_addr = 4'(a); acc_wdata = 16'(d);
        @(negedge clk);
        acc_en = 1'b0; acc_wr = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        @(negedge clk);
        acc_en = 1'b1; acc_wr = 1'b0; acc_addr = 4'(a);
        @(negedge clk);
        v = int'(acc_rdata);
        acc_en = 1'b0;
    endtask

    task automatic pulse(input int v);
        @(negedge clk);
        std_evt_in = 8'(v);
        @(negedge clk);
        std_evt_in = '0;
    endtask

    task automatic set_cond(input int v);
        @(negedge clk);
        q_cond_in = 16'(v);
        @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 status byte", int'(status_byte), 0);
        check("R1 srq", int'(srq), 0);
        rd(7, v); check("R1 rising filter", v, 'hFFFF);
        rd(8, v); check("R1 falling filter", v, 0);
        rd(3, v); check("R1 standard enable", v, 0);

        // R2 R3 R5: command error with both masks 32 polls as 96
        wr(3, 32); wr(1, 32);
        pulse(32);
        check("R5 srq after command error", int'(srq), 1);
        rd(0, v); check("R5 serial poll 96", v, 96);
        rd(2, v); check("R2 R9 event read", v, 32);
        check("R12 srq drops after read", int'(srq), 0);
        rd(2, v); check("R9 cleared", v, 0);
        // R11 idle read data
        @(negedge clk); check("R11 idle rdata", int'(acc_rdata), 0);

        // R3: unmasked event does not summarise
        pulse(1);
        check("R3 masked bit", int'(status_byte), 0);
        rd(2, v); check("R2 unmasked bit latched", v, 1);

        // R5: service-request bit 6 not stored
        wr(1, 'hFF);
        rd(1, v); check("R5 svc enable readback", v, 'hBF);

        // R6 R7 R4: calibration off polls as 72
        wr(1, 8); wr(6, 'h64);
        @(negedge clk); autocal_off = 1'b1;
        @(negedge clk);
        rd(0, v); check("R7 serial poll 72", v, 72);
        rd(4, v); check("R6 forced condition", v, 'h64);
        rd(5, v); check("R9 questionable read", v, 'h64);
        rd(4, v); check("R9 condition not cleared", v, 'h64);
        @(negedge clk); autocal_off = 1'b0;
        @(negedge clk);
        rd(5, v); check("R7 no falling latch by default", v, 0);

        // R8: falling filter only
        wr(7, 0); wr(8, 1);
        set_cond(1);
        rd(5, v); check("R7 rise blocked", v, 0);
        set_cond(0);
        rd(5, v); check("R8 fall latched", v, 1);

        // R8: both filters on bit 1
        wr(7, 2); wr(8, 2);
        set_cond(2);
        rd(5, v); check("R8 rise with both", v, 2);
        set_cond(0);
        rd(5, v); check("R8 fall with both", v, 2);

        // R10: clear status
        pulse(32);
        @(negedge clk); clr_status = 1'b1; std_evt_in = 8'h10;
        @(negedge clk); clr_status = 1'b0; std_evt_in = '0;
        check("R10 status byte cleared", int'(status_byte), 0);
        rd(2, v); check("R10 clear dominates", v, 0);
        rd(3, v); check("R10 enable kept", v, 32);

        // R9: event during read survives
        pulse(1);
        @(negedge clk);
        acc_en = 1'b1; acc_wr = 1'b0; acc_addr = 4'd2; std_evt_in = 8'h04;
        @(negedge clk);
        v = int'(acc_rdata);
        acc_en = 1'b0; std_evt_in = '0;
        check("R9 read returns old", v, 1);
        rd(2, v); check("R9 new event kept", v, 4);

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule